// File: doc/BRIEF.md
# Multi-port I2C hub repeater

This block is a clocked digital model of a five-port hub for the two I2C wires. Each port delivers two sampled flags per wire. One flag says the wire reads low at the ordinary threshold. The other says an outside device pulls it below the hub's own low level. A low forced by an outside device on any active port is repeated as a hub-driven pull-down on every other active port. Every segment is therefore one hop from every other segment, so arbitration and clock stretching keep working across the hub.

Several hubs form one cluster through a two-wire open-drain expansion bus per I2C wire. The first wire marks a low period that some hub is holding. The second wire marks that an outside driver is still pulling somewhere in the cluster. Release follows a fixed order:
- the last outside driver lets go;
- the hub keeps its pull-down for a settle delay;
- the hub frees that last port;
- the hub releases the first wire once the second wire is high and either the last port reads high or a rise timeout of one microsecond expires;
- the other ports are freed only after both wires read high.

This order keeps the hub free of lock-up without a direction input. SDA and SCL each run their own copy of the engine.

Top module: `i2c_hub_repeater`

## Requirements
- R1: While reset is low, and in the first cycle after it rises, every port pull-down and all four expansion drivers are released (0).
- R2: When an outside hard low appears on an active, idle port, the next cycle shows both expansion drivers of that wire asserted (1 = pull low). The same cycle shows the pull-down asserted on every other active port and never on the port that started the low period.
- R3: Port 0 is always active. Port n (1 to 4) is active only while en_i[n-1] is 1. The flags of an inactive port are ignored, and its pull-down is never asserted.
- R4: While any outside hard low remains on the wire, the second expansion driver stays asserted. One cycle after the last one disappears, that driver is released. All pull-downs, including the one on the last driven port, are held for SETTLE_CYC cycles. After that, the pull-down on the last driven port is released.
- R5: After the settle delay, the first expansion driver is released only in a cycle after the second expansion wire reads high. A second condition must also hold: the last driven port reads high, or CLK_MHZ cycles have passed since the settle delay ended.
- R6: After the first expansion driver is released, the other pull-downs stay asserted until both expansion wires read high. They drop one cycle later.
- R7: If the first expansion wire reads low with no low on any local port, the hub pulls down every active port and drives neither expansion wire. It releases them one cycle after both wires read high.
- R8: An outside hard low that appears during the settle delay or the rise wait restarts the hold. The second expansion driver is asserted again, and the new port becomes the last driven port.
- R9: The SDA and SCL engines are independent: activity on one wire leaves the other wire's outputs released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | NPORTS-1 | Enable of ports 1..NPORTS-1, bit k for port k+1 |
| sda_low_i | input | NPORTS | SDA reads low at the ordinary threshold, per port |
| sda_hard_i | input | NPORTS | SDA pulled below the hub low level by an outside device, per port |
| scl_low_i | input | NPORTS | SCL reads low at the ordinary threshold, per port |
| scl_hard_i | input | NPORTS | SCL pulled below the hub low level by an outside device, per port |
| sda_pd_o | output | NPORTS | SDA open-drain pull-down, per port (1 = pull low) |
| scl_pd_o | output | NPORTS | SCL open-drain pull-down, per port (1 = pull low) |
| xsda_hold_i | input | 1 | Sampled first SDA expansion wire (0 = low) |
| xsda_ext_i | input | 1 | Sampled second SDA expansion wire (0 = low) |
| xsda_hold_o | output | 1 | Pull-down on the first SDA expansion wire |
| xsda_ext_o | output | 1 | Pull-down on the second SDA expansion wire |
| xscl_hold_i | input | 1 | Sampled first SCL expansion wire (0 = low) |
| xscl_ext_i | input | 1 | Sampled second SCL expansion wire (0 = low) |
| xscl_hold_o | output | 1 | Pull-down on the first SCL expansion wire |
| xscl_ext_o | output | 1 | Pull-down on the second SCL expansion wire |

## Verification
The bench builds the hub with its defaults: five ports, CLK_MHZ of 50 (a 50-cycle rise timeout) and a settle delay of 4 cycles. At that size every enable pattern can be crossed with every starting port on both wires. The bench models the wired-AND expansion bus and a second hub that can hold either wire, which brings the follower path and the blocked release within reach. The short timeout lets a stuck port be waited out to the exact cycle.

// File: rtl/hub_pkg.sv
// Shared definitions for the I2C hub repeater.
// Assumes two I2C wires per hub (data and clock), each with its own engine.
package hub_pkg;

    localparam int unsigned HUB_LINES = 2;
    localparam int unsigned LINE_SDA  = 0;
    localparam int unsigned LINE_SCL  = 1;

    // Phases of one low period as seen by a single wire engine
    typedef enum logic [2:0] {
        ST_IDLE,    // wire released everywhere
        ST_FOLLOW,  // another hub holds the period, mirror it
        ST_HOLD,    // an outside driver on a local port holds the wire
        ST_SETTLE,  // last local driver gone, keep pulling for the settle delay
        ST_RISE,    // last port freed, waiting for it to rise or time out
        ST_DRAIN    // own hold released, waiting for both wires to read high
    } hub_state_t;

endpackage

// File: rtl/hub_port_mask.sv
// Applies the per-port enables to the sampled input flags of one wire.
// Port 0 has no enable and is always active; port n uses en_i[n-1].
// Assumes the flags are already synchronous to clk.
module hub_port_mask #(
    parameter int unsigned NPORTS = 5
) (
    input  logic [NPORTS-2:0] en_i,
    input  logic [NPORTS-1:0] low_i,
    input  logic [NPORTS-1:0] hard_i,
    output logic [NPORTS-1:0] act_o,
    output logic [NPORTS-1:0] low_o,
    output logic [NPORTS-1:0] hard_o
);

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        if (g == 0) begin : g_fixed
            // Port 0 is active at all times
            assign act_o[g] = 1'b1;
        end else begin : g_enabled
            // Other ports follow their enable
            assign act_o[g] = en_i[g-1];
        end
        // Inactive ports never reach the hub
        assign low_o[g]  = low_i[g]  & act_o[g];
        assign hard_o[g] = hard_i[g] & act_o[g];
    end

endmodule

// File: rtl/hub_line_engine.sv
// Repeat and release engine for one I2C wire of the hub.
// - Captures the ports that start a low period.
// - Drives the other active ports low while the period lasts.
// - Runs the two-wire expansion handshake that orders the release.
// Assumes masked inputs, expansion wires sampled as wired-AND (0 = low),
// SETTLE_CYC >= 1 and RISE_CYC >= 1.
module hub_line_engine
    import hub_pkg::*;
#(
    parameter int unsigned NPORTS     = 5,
    parameter int unsigned SETTLE_CYC = 4,
    parameter int unsigned RISE_CYC   = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] act_i,
    input  logic [NPORTS-1:0] low_i,
    input  logic [NPORTS-1:0] hard_i,
    input  logic              hold_wire_i,
    input  logic              ext_wire_i,
    output logic [NPORTS-1:0] pd_o,
    output logic              hold_drv_o,
    output logic              ext_drv_o
);

    localparam int unsigned CNT_MAX = (SETTLE_CYC > RISE_CYC) ? SETTLE_CYC : RISE_CYC;
    localparam int unsigned CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] SETTLE_LOAD = CW'(SETTLE_CYC - 1);
    localparam logic [CW-1:0] RISE_LOAD   = CW'(RISE_CYC - 1);

    hub_state_t        state;
    logic [NPORTS-1:0] src_q;    // ports whose own low opened the period
    logic [NPORTS-1:0] last_q;   // ports that held the last outside low
    logic [CW-1:0]     cnt_q;    // settle or rise-timeout countdown

    logic any_low, any_hard, last_low, wires_high;

    // Summary terms of the current inputs
    always_comb begin
        any_low    = |low_i;
        any_hard   = |hard_i;
        last_low   = |(low_i & last_q);
        wires_high = hold_wire_i & ext_wire_i;
    end

    // Period sequencing and release countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            src_q  <= '0;
            last_q <= '0;
            cnt_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (any_hard) begin
                        state  <= ST_HOLD;
                        src_q  <= low_i | hard_i;
                        last_q <= hard_i;
                    end else if (any_low || !hold_wire_i) begin
                        state  <= ST_FOLLOW;
                        src_q  <= low_i;
                        last_q <= '0;
                    end
                end
                ST_FOLLOW: begin
                    if (any_hard) begin
                        state  <= ST_HOLD;
                        last_q <= hard_i;
                    end else if (wires_high) begin
                        state  <= ST_IDLE;
                    end
                end
                ST_HOLD: begin
                    if (any_hard) begin
                        last_q <= hard_i;
                    end else begin
                        state <= ST_SETTLE;
                        cnt_q <= SETTLE_LOAD;
                    end
                end
                ST_SETTLE: begin
                    if (any_hard) begin
                        state  <= ST_HOLD;
                        last_q <= hard_i;
                    end else if (cnt_q == '0) begin
                        state <= ST_RISE;
                        cnt_q <= RISE_LOAD;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_RISE: begin
                    if (any_hard) begin
                        state  <= ST_HOLD;
                        last_q <= hard_i;
                    end else if (ext_wire_i && (!last_low || cnt_q == '0)) begin
                        state <= ST_DRAIN;
                    end else if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (any_hard) begin
                        state  <= ST_HOLD;
                        last_q <= hard_i;
                    end else if (wires_high) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output drive per phase; inactive ports are never pulled
    always_comb begin
        pd_o       = '0;
        hold_drv_o = 1'b0;
        ext_drv_o  = 1'b0;
        case (state)
            ST_FOLLOW: pd_o = act_i & ~src_q;
            ST_HOLD: begin
                pd_o       = act_i & ~src_q;
                hold_drv_o = 1'b1;
                ext_drv_o  = 1'b1;
            end
            ST_SETTLE: begin
                pd_o       = act_i & ~src_q;
                hold_drv_o = 1'b1;
            end
            ST_RISE: begin
                pd_o       = act_i & ~src_q & ~last_q;
                hold_drv_o = 1'b1;
            end
            ST_DRAIN: pd_o = act_i & ~src_q & ~last_q;
            default: pd_o = '0;
        endcase
    end

endmodule

// File: rtl/i2c_hub_repeater.sv
// Multi-port I2C hub repeater: one masking stage and one engine per wire.
// Assumes all inputs are synchronous to clk and that each expansion wire is
// an open-drain wired-AND bus shared with the other hubs of the cluster.
module i2c_hub_repeater
    import hub_pkg::*;
#(
    parameter int unsigned NPORTS     = 5,
    parameter int unsigned CLK_MHZ    = 50,
    parameter int unsigned SETTLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-2:0] en_i,
    input  logic [NPORTS-1:0] sda_low_i,
    input  logic [NPORTS-1:0] sda_hard_i,
    input  logic [NPORTS-1:0] scl_low_i,
    input  logic [NPORTS-1:0] scl_hard_i,
    output logic [NPORTS-1:0] sda_pd_o,
    output logic [NPORTS-1:0] scl_pd_o,
    input  logic              xsda_hold_i,
    input  logic              xsda_ext_i,
    output logic              xsda_hold_o,
    output logic              xsda_ext_o,
    input  logic              xscl_hold_i,
    input  logic              xscl_ext_i,
    output logic              xscl_hold_o,
    output logic              xscl_ext_o
);

    localparam int unsigned RISE_CYC = CLK_MHZ;  // one microsecond

    logic [HUB_LINES-1:0][NPORTS-1:0] low_raw, hard_raw, low_m, hard_m, act_m, pd_w;
    logic [HUB_LINES-1:0]             hold_in, ext_in, hold_drv, ext_drv;

    // Gather both wires into per-line vectors
    always_comb begin
        low_raw[LINE_SDA]  = sda_low_i;
        low_raw[LINE_SCL]  = scl_low_i;
        hard_raw[LINE_SDA] = sda_hard_i;
        hard_raw[LINE_SCL] = scl_hard_i;
        hold_in[LINE_SDA]  = xsda_hold_i;
        hold_in[LINE_SCL]  = xscl_hold_i;
        ext_in[LINE_SDA]   = xsda_ext_i;
        ext_in[LINE_SCL]   = xscl_ext_i;
    end

    for (genvar l = 0; l < HUB_LINES; l++) begin : g_line
        hub_port_mask #(.NPORTS(NPORTS)) u_mask (
            .en_i   (en_i),
            .low_i  (low_raw[l]),
            .hard_i (hard_raw[l]),
            .act_o  (act_m[l]),
            .low_o  (low_m[l]),
            .hard_o (hard_m[l])
        );

        hub_line_engine #(
            .NPORTS     (NPORTS),
            .SETTLE_CYC (SETTLE_CYC),
            .RISE_CYC   (RISE_CYC)
        ) u_engine (
            .clk         (clk),
            .rst_n       (rst_n),
            .act_i       (act_m[l]),
            .low_i       (low_m[l]),
            .hard_i      (hard_m[l]),
            .hold_wire_i (hold_in[l]),
            .ext_wire_i  (ext_in[l]),
            .pd_o        (pd_w[l]),
            .hold_drv_o  (hold_drv[l]),
            .ext_drv_o   (ext_drv[l])
        );
    end

    // Spread the per-line results back to the named ports
    always_comb begin
        sda_pd_o    = pd_w[LINE_SDA];
        scl_pd_o    = pd_w[LINE_SCL];
        xsda_hold_o = hold_drv[LINE_SDA];
        xscl_hold_o = hold_drv[LINE_SCL];
        xsda_ext_o  = ext_drv[LINE_SDA];
        xscl_ext_o  = ext_drv[LINE_SCL];
    end

endmodule

// File: rtl/i2c_hub_chk.sv
// Port-level protocol checker for the hub repeater, bound to its top.
// Assumes the expansion inputs are the wired-AND of all hubs' drivers.
module i2c_hub_chk #(
    parameter int unsigned NPORTS = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NPORTS-2:0] en_i,
    input logic [NPORTS-1:0] sda_pd_o,
    input logic [NPORTS-1:0] scl_pd_o,
    input logic              xsda_hold_i,
    input logic              xsda_ext_i,
    input logic              xsda_hold_o,
    input logic              xsda_ext_o,
    input logic              xscl_hold_i,
    input logic              xscl_ext_i,
    input logic              xscl_hold_o,
    input logic              xscl_ext_o
);

    logic [1:0][NPORTS-1:0] pd;
    logic [1:0] h_o, e_o, h_i, e_i;

    // Per-line views for the generated properties
    always_comb begin
        pd[0] = sda_pd_o;    pd[1] = scl_pd_o;
        h_o[0] = xsda_hold_o; h_o[1] = xscl_hold_o;
        e_o[0] = xsda_ext_o;  e_o[1] = xscl_ext_o;
        h_i[0] = xsda_hold_i; h_i[1] = xscl_hold_i;
        e_i[0] = xsda_ext_i;  e_i[1] = xscl_ext_i;
    end

    for (genvar l = 0; l < 2; l++) begin : g_line
        // R1: outputs start released after reset
        a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (pd[l] == '0 && !h_o[l] && !e_o[l]));

        // R2: the hold driver only starts together with the outside-low driver
        a_r2_pair_start: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(h_o[l]) |-> e_o[l]);

        // R4: the outside-low driver is only ever asserted inside a hold
        a_r4_ext_inside_hold: assert property (@(posedge clk) disable iff (!rst_n)
            e_o[l] |-> h_o[l]);

        // R5: hold is only released after the outside-low wire read high
        a_r5_release_gate: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(h_o[l]) |-> $past(e_i[l]));

        // R6: pull-downs drop outside a hold only after both wires read high
        a_r6_drain_order: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(|pd[l]) && pd[l] == '0 && !$past(h_o[l]) && $stable(en_i))
            |-> $past(h_i[l] && e_i[l]));

        for (genvar p = 1; p < NPORTS; p++) begin : g_port
            // R3: a disabled port is never pulled down
            a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                !en_i[p-1] |-> !pd[l][p]);
        end
    end

endmodule

bind i2c_hub_repeater i2c_hub_chk #(.NPORTS(NPORTS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .sda_pd_o    (sda_pd_o),
    .scl_pd_o    (scl_pd_o),
    .xsda_hold_i (xsda_hold_i),
    .xsda_ext_i  (xsda_ext_i),
    .xsda_hold_o (xsda_hold_o),
    .xsda_ext_o  (xsda_ext_o),
    .xscl_hold_i (xscl_hold_i),
    .xscl_ext_i  (xscl_ext_i),
    .xscl_hold_o (xscl_hold_o),
    .xscl_ext_o  (xscl_ext_o)
);

// File: tb/i2c_hub_repeater_test.sv
// Self-checking bench: models each bus wire, the wired-AND expansion bus and
// a second hub that can hold either expansion wire.
module i2c_hub_repeater_test;

    localparam int unsigned NP     = 5;
    localparam int unsigned MHZ    = 50;
    localparam int unsigned SETTLE = 4;
    localparam int unsigned TMO    = MHZ;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-2:0] en = '1;
    logic [1:0][NP-1:0] ext = '0;   // outside hard drivers per line
    logic [1:0][NP-1:0] stk = '0;   // ordinary-only lows (slow rise)
    logic [1:0] oth_h = '0, oth_e = '0;  // second hub pulling the wires

    logic [1:0][NP-1:0] pdv;
    logic [1:0] h_o, e_o;
    logic [NP-1:0] sda_pd, scl_pd;
    logic xsda_h_o, xsda_e_o, xscl_h_o, xscl_e_o;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    assign pdv[0] = sda_pd;
    assign pdv[1] = scl_pd;
    assign h_o = {xscl_h_o, xsda_h_o};
    assign e_o = {xscl_e_o, xsda_e_o};

    i2c_hub_repeater #(.NPORTS(NP), .CLK_MHZ(MHZ), .SETTLE_CYC(SETTLE)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .sda_low_i   (ext[0] | stk[0] | sda_pd),
        .sda_hard_i  (ext[0]),
        .scl_low_i   (ext[1] | stk[1] | scl_pd),
        .scl_hard_i  (ext[1]),
        .sda_pd_o    (sda_pd),
        .scl_pd_o    (scl_pd),
        .xsda_hold_i (~(xsda_h_o | oth_h[0])),
        .xsda_ext_i  (~(xsda_e_o | oth_e[0])),
        .xsda_hold_o (xsda_h_o),
        .xsda_ext_o  (xsda_e_o),
        .xscl_hold_i (~(xscl_h_o | oth_h[1])),
        .xscl_ext_i  (~(xscl_e_o | oth_e[1])),
        .xscl_hold_o (xscl_h_o),
        .xscl_ext_o  (xscl_e_o)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [NP-1:0] act, expd;
        tick(); tick(); tick();
        chk("R1 pd in reset", 32'({sda_pd, scl_pd}), 0);
        chk("R1 exp in reset", 32'({h_o, e_o}), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 pd after reset", 32'({sda_pd, scl_pd}), 0);
        chk("R1 exp after reset", 32'({h_o, e_o}), 0);

        // Sweep: every line x starting port x enable pattern
        for (int l = 0; l < 2; l++) begin
            for (int p = 0; p < NP; p++) begin
                for (int e = 0; e < (1 << (NP-1)); e++) begin
                    en = (NP-1)'(e);
                    act = {en, 1'b1};
                    tick();
                    ext[l][p] = 1'b1;
                    tick();
                    if (!act[p]) begin
                        chk("R3 disabled port ignored pd", 32'(pdv[l]), 0);
                        chk("R3 disabled port ignored exp", 32'({h_o[l], e_o[l]}), 0);
                        ext[l][p] = 1'b0;
                        tick();
                        continue;
                    end
                    expd = act & ~(NP'(1) << p);
                    chk("R2 pd on other active ports", 32'(pdv[l]), 32'(expd));
                    chk("R2 both exp drivers", 32'({h_o[l], e_o[l]}), 3);
                    chk("R3 no pd on inactive", 32'(pdv[l] & ~act), 0);
                    chk("R9 other line quiet", 32'({pdv[1-l], h_o[1-l], e_o[1-l]}), 0);
                    ext[l][p] = 1'b0;
                    tick();
                    chk("R4 exp2 freed, exp1 held", 32'({h_o[l], e_o[l]}), 2);
                    chk("R4 pd held in settle", 32'(pdv[l]), 32'(expd));
                    repeat (SETTLE - 1) tick();
                    chk("R4 pd held to end of settle", 32'(pdv[l]), 32'(expd));
                    tick();
                    chk("R5 hold during rise", 32'(h_o[l]), 1);
                    tick();
                    chk("R5 hold freed when port high", 32'(h_o[l]), 0);
                    chk("R6 pd held until wires high", 32'(pdv[l]), 32'(expd));
                    tick();
                    chk("R6 pd freed after wires high", 32'(pdv[l]), 0);
                end
            end
        end
        en = '1;
        tick();

        // R4/R5: last driver not the source, slow rise ends by timeout
        ext[0][0] = 1'b1; tick();
        ext[0][1] = 1'b1; tick();
        ext[0][0] = 1'b0; tick();
        chk("R4 exp2 kept while port 1 held", 32'(e_o[0]), 1);
        ext[0][1] = 1'b0; stk[0][1] = 1'b1; tick();
        chk("R4 last port still pulled in settle", 32'(pdv[0]), 32'h1E);
        repeat (SETTLE - 1) tick();
        tick();
        chk("R4 last port freed after settle", 32'(pdv[0]), 32'h1C);
        repeat (TMO - 1) tick();
        chk("R5 hold kept before timeout", 32'(h_o[0]), 1);
        tick();
        chk("R5 hold freed on timeout", 32'(h_o[0]), 0);
        stk[0][1] = 1'b0; tick();
        chk("R6 pd freed after timeout path", 32'(pdv[0]), 0);

        // R5: second hub keeps the outside-low wire down
        ext[0][0] = 1'b1; tick();
        oth_e[0] = 1'b1; ext[0][0] = 1'b0; tick();
        repeat (SETTLE - 1) tick();
        tick();
        repeat (TMO + 5) tick();
        chk("R5 hold kept while exp2 low", 32'(h_o[0]), 1);
        oth_e[0] = 1'b0; tick();
        chk("R5 hold freed once exp2 high", 32'(h_o[0]), 0);
        tick();
        chk("R6 pd freed", 32'(pdv[0]), 0);

        // R7: follower of another hub, partial enables
        en = 4'b1010; tick();
        oth_h[1] = 1'b1; tick();
        chk("R7 follower pd all active", 32'(pdv[1]), 32'h15);
        chk("R7 follower drives no exp", 32'({h_o[1], e_o[1]}), 0);
        oth_h[1] = 1'b0; oth_e[1] = 1'b1; tick();
        chk("R7 follower waits for both wires", 32'(pdv[1]), 32'h15);
        oth_e[1] = 1'b0; tick();
        chk("R7 follower released", 32'(pdv[1]), 0);
        en = '1; tick();

        // R8: new outside low during the rise wait
        ext[0][0] = 1'b1; tick();
        ext[0][0] = 1'b0; tick();
        repeat (SETTLE - 1) tick();
        tick();
        chk("R8 in rise exp2 free", 32'(e_o[0]), 0);
        ext[0][2] = 1'b1; tick();
        chk("R8 exp2 asserted again", 32'(e_o[0]), 1);
        chk("R8 pd restored", 32'(pdv[0]), 32'h1E);
        ext[0][2] = 1'b0; tick();
        repeat (SETTLE - 1) tick();
        tick();
        chk("R8 new last port freed", 32'(pdv[0]), 32'h1A);
        tick();
        chk("R8 hold freed", 32'(h_o[0]), 0);
        tick();
        chk("R8 pd freed", 32'(pdv[0]), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule